// File: doc/BRIEF.md
# FIFO Level and Error Interrupt Status

This block produces the raw interrupt status for an external bus interface that owns a write FIFO and a non-blocking read FIFO. Two status bits follow the live FIFO levels. The write bit is set while enough write entries are free, and the read bit is set while enough read entries hold data. Each of these bits is compared against its own programmable trigger level.

A third status bit reports errors. It is the OR of three latched causes:
- the write FIFO is full,
- a read has stalled,
- a not-ready handshake has held one transaction longer than a programmable wait limit.

Each cause has its own enable. A wait limit of zero turns the timeout off. Software clears a latched cause by writing 1 to its bit.

A mask register selects which raw bits drive the single interrupt line. All outputs are registered and change one clock after their inputs.

Top module: `fifo_irq_status`

## Requirements
- R1: During and right after reset, `raw_status` reads 3'b100, `err_flags` reads 0, `irq` is 0, and the interrupt mask is 0.
- R2: `raw_status[2]` is 1 one clock after (WR_DEPTH − `wr_level`) ≥ `wr_trig`, and 0 otherwise. A trigger of 0 keeps it set even when the write FIFO is full.
- R3: `raw_status[1]` is 1 one clock after `rd_trig` ≠ 0 and `rd_level` ≥ `rd_trig`, and 0 otherwise. A read trigger of 0 disables the bit.
- R4: `err_flags[0]` (full cause) latches one clock after a cycle in which `wr_level` equals WR_DEPTH while `wfull_en` is 1. With `wfull_en` at 0, a full FIFO leaves it clear.
- R5: `err_flags[1]` (stall cause) latches one clock after a cycle in which `rd_stall` and `rstall_en` are both 1. With `rstall_en` at 0, a stall leaves it clear.
- R6: `raw_status[0]` equals the OR of `err_flags`. It drops in the same clock as the last latched cause clears.
- R7: With `max_wait` = M ≠ 0, `err_flags[2]` (timeout cause) latches in the (M+1)-th consecutive clock that `not_ready` is held within one transaction. Holding it for exactly M clocks raises nothing.
- R8: With `max_wait` = 0, `err_flags[2]` never latches, however long `not_ready` is held.
- R9: The wait count restarts when `not_ready` drops or `xact_start` pulses. A timeout fires at most once per held transaction, so clearing it while `not_ready` is still held does not re-raise it.
- R10: A write with `reg_sel` = 1 clears each `err_flags` bit whose `reg_wdata` bit is 1 and leaves the other bits unchanged. If a new event for a cause arrives in the same clock as its clear, the bit stays set.
- R11: A write with `reg_sel` = 0 loads the 3-bit mask from `reg_wdata`. `irq` is the OR of (`raw_status` AND mask), and is registered alongside `raw_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_level | input | $clog2(WR_DEPTH+1) | Write FIFO occupancy |
| rd_level | input | $clog2(RD_DEPTH+1) | Read FIFO valid entries |
| wr_trig | input | $clog2(WR_DEPTH+1) | Free-entry trigger for the write bit |
| rd_trig | input | $clog2(RD_DEPTH+1) | Valid-entry trigger for the read bit, 0 = off |
| wfull_en | input | 1 | Enables the write-full error cause |
| rstall_en | input | 1 | Enables the read-stall error cause |
| rd_stall | input | 1 | Read stalled indication |
| max_wait | input | WAIT_W | Wait limit in clocks, 0 = timeout off |
| not_ready | input | 1 | Not-ready handshake holding the transaction |
| xact_start | input | 1 | Pulse marking the start of a new transaction |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = mask register, 1 = error clear register |
| reg_wdata | input | 3 | Register write data |
| raw_status | output | 3 | {write trigger, read trigger, error} |
| err_flags | output | 3 | Latched causes {timeout, stall, full} |
| irq | output | 1 | Masked interrupt line |

## Verification
The bench probes the trigger boundaries exactly at equality and one step past it. A comparator that is off by one, or that compares occupancy instead of free entries, shows a wrong write bit there. Timeout holds of exactly M and M+1 clocks expose a counter that fires one cycle early or late. A long hold after a clear catches a timer that re-fires every cycle. A restart through `xact_start` catches a counter that ignores transaction boundaries. A clear that lands in the same cycle as a fresh full event would drop the bit in a design that gives the clear priority. A partial clear would wipe neighbouring causes in a design that decodes the write data wrongly.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int NUM_RAW   = 3;
  localparam int RAW_WR    = 2;
  localparam int RAW_RD    = 1;
  localparam int RAW_ERR   = 0;
  localparam int NUM_CAUSE = 3;
  localparam int CAUSE_FULL  = 0;
  localparam int CAUSE_STALL = 1;
  localparam int CAUSE_TMO   = 2;
  localparam logic [NUM_RAW-1:0] RAW_RESET = 3'b100;

  typedef enum logic {
    SEL_MASK  = 1'b0,
    SEL_CLEAR = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/lvl_trigger.sv
module lvl_trigger #(
  parameter int DEPTH     = 8,
  parameter bit FREE_MODE = 1'b1,
  localparam int LW       = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] trig,
  output logic          hit,
  output logic          full
);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  assign full = (level == DEPTH_L);

  generate
    if (FREE_MODE) begin : g_free
      logic [LW-1:0] free_cnt;
      always_comb begin
        free_cnt = DEPTH_L - level;
        hit      = (free_cnt >= trig);
      end
    end else begin : g_valid
      always_comb begin
        hit = (trig != '0) && (level >= trig);
      end
    end
  endgenerate
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WAIT_W-1:0] limit,
  input  logic              hold,
  input  logic              restart,
  output logic              expire
);
  logic [WAIT_W-1:0] cnt_q;
  logic              fired_q;
  logic              armed;

  always_comb begin
    armed  = (limit != '0);
    expire = armed && hold && !restart && !fired_q && (cnt_q >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (restart || !hold) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (expire) begin
      fired_q <= 1'b1;
    end else if (!fired_q && armed && (cnt_q < limit)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/err_cause_reg.sv
module err_cause_reg #(
  parameter int NC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] evt,
  input  logic [NC-1:0] clr,
  output logic [NC-1:0] nxt,
  output logic [NC-1:0] cause_q
);
  always_comb begin
    nxt = cause_q;
    for (int i = 0; i < NC; i++) begin
      if (evt[i])      nxt[i] = 1'b1;
      else if (clr[i]) nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= nxt;
  end
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
  import fifo_irq_pkg::*;
#(
  parameter int WR_DEPTH = 8,
  parameter int RD_DEPTH = 8,
  parameter int WAIT_W   = 16,
  localparam int WLW     = $clog2(WR_DEPTH + 1),
  localparam int RLW     = $clog2(RD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WLW-1:0]    wr_level,
  input  logic [RLW-1:0]    rd_level,
  input  logic [WLW-1:0]    wr_trig,
  input  logic [RLW-1:0]    rd_trig,
  input  logic              wfull_en,
  input  logic              rstall_en,
  input  logic              rd_stall,
  input  logic [WAIT_W-1:0] max_wait,
  input  logic              not_ready,
  input  logic              xact_start,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [2:0]        reg_wdata,
  output logic [2:0]        raw_status,
  output logic [2:0]        err_flags,
  output logic              irq
);
  logic wr_hit, wr_full, rd_hit, rd_full_unused;
  logic tmo_evt;
  logic [NUM_CAUSE-1:0] evt, clr, cause_nxt;
  logic [NUM_RAW-1:0]   raw_nxt, mask_q, mask_nxt;

  lvl_trigger #(.DEPTH(WR_DEPTH), .FREE_MODE(1'b1)) u_wr_trig (
    .level(wr_level), .trig(wr_trig), .hit(wr_hit), .full(wr_full)
  );

  lvl_trigger #(.DEPTH(RD_DEPTH), .FREE_MODE(1'b0)) u_rd_trig (
    .level(rd_level), .trig(rd_trig), .hit(rd_hit), .full(rd_full_unused)
  );

  wait_timer #(.WAIT_W(WAIT_W)) u_wait (
    .clk(clk), .rst(rst), .limit(max_wait), .hold(not_ready),
    .restart(xact_start), .expire(tmo_evt)
  );

  always_comb begin
    evt              = '0;
    evt[CAUSE_FULL]  = wr_full && wfull_en;
    evt[CAUSE_STALL] = rd_stall && rstall_en;
    evt[CAUSE_TMO]   = tmo_evt;
    clr = (reg_we && reg_sel == SEL_CLEAR) ? reg_wdata : '0;
  end

  err_cause_reg #(.NC(NUM_CAUSE)) u_cause (
    .clk(clk), .rst(rst), .evt(evt), .clr(clr),
    .nxt(cause_nxt), .cause_q(err_flags)
  );

  always_comb begin
    raw_nxt          = '0;
    raw_nxt[RAW_WR]  = wr_hit;
    raw_nxt[RAW_RD]  = rd_hit;
    raw_nxt[RAW_ERR] = |cause_nxt;
    mask_nxt = (reg_we && reg_sel == SEL_MASK) ? reg_wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_status <= RAW_RESET;
      mask_q     <= '0;
      irq        <= 1'b0;
    end else begin
      raw_status <= raw_nxt;
      mask_q     <= mask_nxt;
      irq        <= |(raw_nxt & mask_nxt);
    end
  end
endmodule

// File: rtl/fifo_irq_status_chk.sv
module fifo_irq_status_chk #(
  parameter int WR_DEPTH = 8,
  parameter int RD_DEPTH = 8,
  parameter int WAIT_W   = 16,
  localparam int WLW     = $clog2(WR_DEPTH + 1),
  localparam int RLW     = $clog2(RD_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [RLW-1:0]    rd_level,
  input logic [RLW-1:0]    rd_trig,
  input logic              wfull_en,
  input logic              rstall_en,
  input logic [WAIT_W-1:0] max_wait,
  input logic [2:0]        raw_status,
  input logic [2:0]        err_flags,
  input logic [2:0]        mask_q,
  input logic              irq
);
  AST_ERR_IS_OR: assert property (@(posedge clk) disable iff (rst)
    raw_status[0] == |err_flags); // R6
  AST_FULL_GATED: assert property (@(posedge clk) disable iff (rst)
    !wfull_en |=> !$rose(err_flags[0])); // R4
  AST_STALL_GATED: assert property (@(posedge clk) disable iff (rst)
    !rstall_en |=> !$rose(err_flags[1])); // R5
  AST_TMO_OFF: assert property (@(posedge clk) disable iff (rst)
    (max_wait == '0) |=> !$rose(err_flags[2])); // R8
  AST_RD_BELOW: assert property (@(posedge clk) disable iff (rst)
    (rd_level < rd_trig) |=> !raw_status[1]); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq == |(raw_status & mask_q)); // R11
endmodule

bind fifo_irq_status fifo_irq_status_chk #(
  .WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH), .WAIT_W(WAIT_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_level(rd_level), .rd_trig(rd_trig),
  .wfull_en(wfull_en), .rstall_en(rstall_en), .max_wait(max_wait),
  .raw_status(raw_status), .err_flags(err_flags), .mask_q(mask_q), .irq(irq)
);

// File: tb/fifo_irq_status_test.sv
`timescale 1ns/1ps
module fifo_irq_status_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  wr_level = '0, rd_level = '0, wr_trig = 4'd4, rd_trig = 4'd4;
  logic        wfull_en = 1'b0, rstall_en = 1'b0, rd_stall = 1'b0;
  logic [15:0] max_wait = '0;
  logic        not_ready = 1'b0, xact_start = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [2:0]  reg_wdata = '0;
  logic [2:0]  raw_status, err_flags;
  logic        irq;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fifo_irq_status uut (
    .clk(clk), .rst(rst), .wr_level(wr_level), .rd_level(rd_level),
    .wr_trig(wr_trig), .rd_trig(rd_trig), .wfull_en(wfull_en),
    .rstall_en(rstall_en), .rd_stall(rd_stall), .max_wait(max_wait),
    .not_ready(not_ready), .xact_start(xact_start), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .raw_status(raw_status),
    .err_flags(err_flags), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FIFO-IRQ FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic sel, input logic [2:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset;
    step(2);
    chk("R1 raw", raw_status, 3'b100);
    chk("R1 flags", err_flags, 0);
    chk("R1 irq", irq, 0);
    rst = 1'b0;
    step();
    reg_write(1'b0, 3'b000);
    chk("R1 mask zero irq", irq, 0);
  endtask

  task automatic t_write_bit;
    wr_trig = 4'd4; wr_level = 4'd4; step();
    chk("R2 free equal trig", raw_status[2], 1);
    wr_level = 4'd5; step();
    chk("R2 free below trig", raw_status[2], 0);
    wr_trig = 4'd0; wr_level = 4'd8; step();
    chk("R2 trig zero full", raw_status[2], 1);
    wr_level = 4'd0; wr_trig = 4'd4; step();
  endtask

  task automatic t_read_bit;
    rd_trig = 4'd4; rd_level = 4'd3; step();
    chk("R3 below trig", raw_status[1], 0);
    rd_level = 4'd4; step();
    chk("R3 at trig", raw_status[1], 1);
    rd_trig = 4'd0; rd_level = 4'd8; step();
    chk("R3 trig zero off", raw_status[1], 0);
    rd_level = 4'd0; rd_trig = 4'd4; step();
  endtask

  task automatic t_full;
    wfull_en = 1'b0; wr_level = 4'd8; step(2);
    chk("R4 disabled", err_flags[0], 0);
    wfull_en = 1'b1; step();
    chk("R4 enabled", err_flags[0], 1);
    chk("R6 raw err set", raw_status[0], 1);
    reg_write(1'b1, 3'b001);
    chk("R10 event wins over clear", err_flags[0], 1);
    wr_level = 4'd0; step();
    reg_write(1'b1, 3'b001);
    chk("R10 clear full", err_flags[0], 0);
    chk("R6 raw err drops", raw_status[0], 0);
    wfull_en = 1'b0;
  endtask

  task automatic t_stall;
    rstall_en = 1'b0; rd_stall = 1'b1; step();
    chk("R5 disabled", err_flags[1], 0);
    rstall_en = 1'b1; step();
    rd_stall = 1'b0; rstall_en = 1'b0;
    chk("R5 enabled", err_flags[1], 1);
    wfull_en = 1'b1; wr_level = 4'd8; step();
    wfull_en = 1'b0; wr_level = 4'd0;
    chk("R5 two causes", err_flags, 3'b011);
    reg_write(1'b1, 3'b010);
    chk("R10 partial clear", err_flags, 3'b001);
    chk("R6 raw err held", raw_status[0], 1);
    reg_write(1'b1, 3'b001);
    chk("R6 raw err clear", raw_status[0], 0);
  endtask

  task automatic t_timeout;
    max_wait = 16'd3;
    not_ready = 1'b1; step(3);
    chk("R7 exactly limit", err_flags[2], 0);
    not_ready = 1'b0; step();
    not_ready = 1'b1; step(4);
    chk("R7 limit plus one", err_flags[2], 1);
    reg_write(1'b1, 3'b100);
    step(5);
    chk("R9 no refire", err_flags[2], 0);
    not_ready = 1'b0; step();
    not_ready = 1'b1; step(2);
    xact_start = 1'b1; step();
    xact_start = 1'b0; step(3);
    chk("R9 restart on new transaction", err_flags[2], 0);
    step();
    chk("R9 fires after restart", err_flags[2], 1);
    not_ready = 1'b0; reg_write(1'b1, 3'b100);
    max_wait = 16'd0; not_ready = 1'b1; step(20);
    chk("R8 limit zero", err_flags[2], 0);
    not_ready = 1'b0; step();
  endtask

  task automatic t_mask;
    wfull_en = 1'b1; wr_level = 4'd8; step();
    wfull_en = 1'b0; wr_level = 4'd0;
    chk("R11 masked off", irq, 0);
    reg_write(1'b0, 3'b001);
    chk("R11 err unmasked", irq, 1);
    reg_write(1'b1, 3'b001);
    chk("R11 irq follows clear", irq, 0);
    reg_write(1'b0, 3'b100);
    chk("R11 write bit unmasked", irq, 1);
    wr_level = 4'd6; step();
    chk("R11 write bit drops", irq, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FIFO-IRQ FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write_bit();
    t_read_bit();
    t_full();
    t_stall();
    t_timeout();
    t_mask();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule